// File: doc/BRIEF.md
# Prescaled Periodic Down-Counter Timer

The block is one timer channel that sits on a small word-addressed register bus and raises an interrupt pulse at a programmable rate. The system clock first passes through an 8-bit prescaler that divides by its setting plus one. A fixed divider follows it and divides by 2, 4, 8 or 16. Each output tick of the divider decrements a 16-bit down-counter.

Software never writes the counter directly. It writes a period value into a buffer register. A manual-update control bit copies the buffer into the counter. When the counter is at zero and a tick arrives, that is the terminal event. In periodic mode the terminal event reloads the counter from the buffer. In single-shot mode it stops the channel. The live count can be read at any time through a read-only observation register. Each terminal event produces a one-cycle interrupt pulse and sets a sticky pending flag, which software clears by writing a one to it.

Top module: `tick_timer`

## Requirements
- R1: After reset every readable register returns 0 and `irq_pulse` is low.
- R2: The registers sit at word indices 0 to 4, on 32-bit spacing. Index 0 holds the prescale value in bits 15:8. Index 1 holds the divider select in bits 1:0. Index 2 is control: bit 0 start, bit 1 manual update, bit 2 periodic reload, bit 3 pending. Index 3 is the 16-bit buffer. Index 4 is the observation register. Bits with no field read as 0, and so do unmapped indices.
- R3: While the channel runs, one counter tick occurs every (P+1)·2^(S+1) clock cycles, where P is the prescale value and S is the divider select. S=3 selects divide-by-16.
- R4: While manual update is set, the counter equals the buffer value, no tick occurs and no interrupt is raised.
- R5: In periodic mode the counter counts from the buffer value B down to 0. The tick after it reaches 0 reloads B. With start written at clock edge s, the interrupt pulses are visible in the cycles after edges s+k·(B+1)·T, for k ≥ 1, where T is the tick period.
- R6: In single-shot mode (reload bit clear) exactly one interrupt is raised. The hardware then clears start and the counter stays at 0.
- R7: While start is clear the count holds its value. Writing 0 to control stops the channel. Restarting resets the prescaler and divider, so the next event comes (c+1)·T cycles after the restart edge, where c is the held count.
- R8: A buffer write made while the channel runs does not change the period in progress. The new value is used from the next reload onward.
- R9: `irq_pulse` is high for exactly one cycle per terminal event. Pending (control bit 3) is then set and stays set until a control write with bit 3 equal to 1.
- R10: Writes to the observation register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Word index of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from `bus_idx`) |
| irq_pulse | output | 1 | One-cycle interrupt on each terminal event |

## Verification
The hardest conditions to reach from the ports are writes that land part-way through a period. Two cases matter: a buffer rewrite while the counter is mid-descent, and a stop-and-restart that arrives between prescaler ticks. The bench stamps every register write with the clock edge that took it. From that edge it computes the held count and the cycle of each expected interrupt. A monitor then checks every pulse against the computed cycle, so an early, late, missing or extra pulse is reported.

// File: rtl/tmr_pkg.sv
// Shared constants for the timer channel: register indices and control bit
// positions. Assumes a 16-bit data bus and word-indexed register access.
package tmr_pkg;
    localparam int BUS_W  = 16;
    localparam int IDX_W  = 3;
    localparam int PRE_W  = 8;
    localparam int SEL_W  = 2;
    localparam int PRE_LSB = 8;

    typedef enum logic [IDX_W-1:0] {
        IDX_CFG0 = 3'd0,
        IDX_CFG1 = 3'd1,
        IDX_CTRL = 3'd2,
        IDX_BUF  = 3'd3,
        IDX_OBS  = 3'd4
    } reg_idx_e;

    localparam int CTL_START = 0;
    localparam int CTL_LOAD  = 1;
    localparam int CTL_AUTO  = 2;
    localparam int CTL_PEND  = 3;
endpackage

// File: rtl/tmr_tickgen.sv
// Two-stage tick generator: a programmable prescaler followed by a
// power-of-two divider (2^(sel+1)). Assumes both stages restart from zero
// whenever run is low.
module tmr_tickgen #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_div,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int DIV_W = 2 ** SEL_W;

    logic [PRE_W-1:0] pcnt;
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] dmask;
    logic             pre_tick;

    // Terminal value of the divider stage for the selected ratio.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) dmask[i] = (i <= int'(div_sel));
    end

    assign pre_tick = run && (pcnt == pre_div);
    assign tick     = pre_tick && (dcnt >= dmask);

    // Prescaler stage: count system cycles up to the programmed value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  pcnt <= '0;
        else if (pre_tick)   pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    // Divider stage: count prescaler outputs up to the selected mask.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  dcnt <= '0;
        else if (tick)       dcnt <= '0;
        else if (pre_tick)   dcnt <= dcnt + 1'b1;
    end

    // R7
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);
endmodule

// File: rtl/tmr_counter.sv
// 16-bit down-counter with buffered reload. Loads the buffer on a manual
// update, reloads it on the terminal event in periodic mode, and flags the
// end of a single-shot run. Assumes tick never coincides with load.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             autold,
    input  logic [CNT_W-1:0] buf_val,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             shot_done
);
    logic terminal;

    assign terminal  = tick && (count == '0);
    assign shot_done = terminal && !autold;

    // Counter update: manual load, terminal reload, or decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (load)               count <= buf_val;
        else if (terminal && autold) count <= buf_val;
        else if (tick && count != '0) count <= count - 1'b1;
    end

    // Registered one-cycle interrupt pulse on each terminal event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= terminal;
    end

    // R5
    reload_from_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && autold && count == '0) |=> (count == $past(buf_val)));
    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));
endmodule

// File: rtl/tmr_regs.sv
// Register file: configuration, control with write-one-to-clear pending,
// period buffer and read-only count view. Assumes single-cycle writes;
// a control write overrides a same-cycle hardware clear of start.
module tmr_regs
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [BUS_W-1:0] count_i,
    input  logic             irq_i,
    input  logic             shot_done_i,
    output logic [PRE_W-1:0] pre_div,
    output logic [SEL_W-1:0] div_sel,
    output logic             start,
    output logic             load,
    output logic             autold,
    output logic [BUS_W-1:0] buf_val
);
    logic pending;
    logic ctl_wr;

    assign ctl_wr = sel && wr && (idx == IDX_CTRL);

    // Configuration and buffer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_div <= '0;
            div_sel <= '0;
            buf_val <= '0;
        end else if (sel && wr) begin
            if (idx == IDX_CFG0) pre_div <= wdata[PRE_LSB +: PRE_W];
            if (idx == IDX_CFG1) div_sel <= wdata[SEL_W-1:0];
            if (idx == IDX_BUF)  buf_val <= wdata;
        end
    end

    // Control bits; single-shot completion clears start unless overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start  <= 1'b0;
            load   <= 1'b0;
            autold <= 1'b0;
        end else if (ctl_wr) begin
            start  <= wdata[CTL_START];
            load   <= wdata[CTL_LOAD];
            autold <= wdata[CTL_AUTO];
        end else if (shot_done_i) begin
            start  <= 1'b0;
        end
    end

    // Sticky pending flag: set by the interrupt, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pending <= 1'b0;
        else if (irq_i)                    pending <= 1'b1;
        else if (ctl_wr && wdata[CTL_PEND]) pending <= 1'b0;
    end

    // Read multiplexer; unused bits and indices return zero.
    always_comb begin
        rdata = '0;
        case (idx)
            IDX_CFG0: rdata[PRE_LSB +: PRE_W] = pre_div;
            IDX_CFG1: rdata[SEL_W-1:0] = div_sel;
            IDX_CTRL: begin
                rdata[CTL_START] = start;
                rdata[CTL_LOAD]  = load;
                rdata[CTL_AUTO]  = autold;
                rdata[CTL_PEND]  = pending;
            end
            IDX_BUF:  rdata = buf_val;
            IDX_OBS:  rdata = count_i;
            default:  rdata = '0;
        endcase
    end

    // R9
    pend_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> pending);
    // R6
    shot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_done_i && !ctl_wr) |=> !start);
endmodule

// File: rtl/tick_timer.sv
// Timer channel top: register file, tick generator and down-counter.
// Counting runs only while start is set and manual update is clear.
module tick_timer
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_pulse
);
    logic [PRE_W-1:0] pre_div;
    logic [SEL_W-1:0] div_sel;
    logic             start, load, autold, run, tick, shot_done;
    logic [BUS_W-1:0] buf_val, count;

    assign run = start && !load;

    tmr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .idx(bus_idx),
        .wdata(bus_wdata), .rdata(bus_rdata), .count_i(count),
        .irq_i(irq_pulse), .shot_done_i(shot_done), .pre_div(pre_div),
        .div_sel(div_sel), .start(start), .load(load), .autold(autold),
        .buf_val(buf_val)
    );

    tmr_tickgen #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_tickgen (
        .clk(clk), .rst_n(rst_n), .run(run), .pre_div(pre_div),
        .div_sel(div_sel), .tick(tick)
    );

    tmr_counter #(.CNT_W(BUS_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .autold(autold),
        .buf_val(buf_val), .count(count), .irq(irq_pulse),
        .shot_done(shot_done)
    );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_idx = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_pulse;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int exp_q[$];
    int s;
    bit done = 1'b0;

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every pulse must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && irq_pulse) begin
            if (exp_q.size() == 0) chk(1'b0, "R5/R9 unexpected irq", cyc, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R5 irq cycle", cyc, e);
            end
        end
    end

    task automatic wr(input int idx, input int data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx[2:0]; bus_wdata = data[15:0];
        @(posedge clk);
        #1;
        s = cyc;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output int val);
        @(negedge clk);
        bus_idx = idx[2:0];
        #1;
        val = int'(bus_rdata);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(posedge clk);
    endtask

    // Driver: configure and start; pushes expected pulse cycles.
    task automatic run_cfg(input int p, input int sel, input int b, input int ctl,
                           input int n_exp, output int t_per);
        wr(0, p << 8);
        wr(1, sel);
        wr(3, b);
        wr(2, 32'hA);
        wr(2, ctl);
        t_per = (p + 1) * (1 << (sel + 1));
        for (int k = 1; k <= n_exp; k++) exp_q.push_back(s + k * (b + 1) * t_per);
    endtask

    task automatic q_empty(input string req);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", cyc, 0);
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, t, s0, c, s2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 5; i++) begin
            rd(i, v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(irq_pulse == 1'b0, "R1 irq low", irq_pulse, 0);

        // R2: field masking and unmapped index
        wr(0, 32'hFFFF); rd(0, v); chk(v == 16'hFF00, "R2 cfg0 mask", v, 16'hFF00);
        wr(1, 32'hFFFF); rd(1, v); chk(v == 3, "R2 cfg1 mask", v, 3);
        wr(3, 32'hBEEF); rd(3, v); chk(v == 16'hBEEF, "R2 buffer", v, 16'hBEEF);
        rd(5, v); chk(v == 0, "R2 unmapped", v, 0);

        // R4: manual update loads buffer and suspends counting
        wr(3, 7); wr(2, 3);
        repeat (30) @(posedge clk);
        rd(4, v); chk(v == 7, "R4 manual load", v, 7);
        wr(2, 0);

        // R10: observation is read-only
        wr(4, 16'h1234); rd(4, v); chk(v == 7, "R10 obs ignores write", v, 7);

        // R3 R5: periodic, P=1 div2, T=4, B=3
        run_cfg(1, 0, 3, 5, 3, t);
        s0 = s;
        wait_to(s0 + 52);
        wr(2, 0);
        repeat (20) @(posedge clk);
        q_empty("R5 missing irq");
        rd(2, v); chk(v == 8, "R9 pending set", v, 8);
        wr(2, 8); rd(2, v); chk(v == 0, "R9 pending cleared", v, 0);

        // R3: divide-by-16, P=0, B=2
        run_cfg(0, 3, 2, 5, 2, t);
        s0 = s;
        wait_to(s0 + 100);
        wr(2, 0);
        repeat (10) @(posedge clk);
        q_empty("R3 div16 missing irq");

        // R6: single-shot, P=0 div4, B=4
        run_cfg(0, 1, 4, 1, 1, t);
        s0 = s;
        wait_to(s0 + 60);
        q_empty("R6 single irq");
        rd(2, v); chk(v == 8, "R6 start cleared", v, 8);
        rd(4, v); chk(v == 0, "R6 count at zero", v, 0);

        // R8: buffer change mid-period, T=2, B=5 then 2
        run_cfg(0, 0, 5, 5, 1, t);
        s0 = s;
        wait_to(s0 + 4);
        wr(3, 2);
        exp_q.push_back(s0 + 18);
        exp_q.push_back(s0 + 24);
        wait_to(s0 + 26);
        wr(2, 0);
        repeat (10) @(posedge clk);
        q_empty("R8 period sequence");

        // R7: stop holds count, restart resets prescaler, T=4, B=9
        run_cfg(1, 0, 9, 5, 0, t);
        s0 = s;
        wait_to(s0 + 9);
        wr(2, 0);
        c = 9 - (s - s0) / t;
        rd(4, v); chk(v == c, "R7 count after stop", v, c);
        repeat (25) @(posedge clk);
        rd(4, v); chk(v == c, "R7 count held", v, c);
        wr(2, 5);
        s2 = s;
        exp_q.push_back(s2 + (c + 1) * t);
        wait_to(s2 + (c + 1) * t + 8);
        wr(2, 0);
        repeat (50) @(posedge clk);
        q_empty("R7 restart timing");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule